// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital front end of a two-channel digital-to-analog converter. A host writes 24-bit command frames over a three-wire serial link made of an active-low frame select, a serial clock and a data line. The block oversamples the three lines with its own system clock. It collects the bits on the falling edges of the serial clock and acts on a complete frame when the frame select rises again.

Each channel has two register stages. The first is an input register that holds a code waiting to be applied. The second is a DAC register that drives the converter code out of the block. A move from the input stage to the DAC stage happens in one of three ways: an explicit command, a combined write-and-update command, or the hardware load pin. The load pin copies data for every channel whose mask bit is clear. Further commands set the power modes, the load mask, the reference control, and the chain and readback enables. One command resets all state.

A parameter selects a 16-bit or a 12-bit code. The serial data-out pin is held low.

Top module: `dac_serial_front`

## Requirements
- R1: A frame is 24 bits. Each bit is taken on a falling edge of `ser_clk` while `frame_n` is low, most significant bit first. Bits 23:20 hold the command, bits 19:16 hold the address and bits 15:0 hold the data field.
- R2: A frame acts only on the rising edge of `frame_n`, and only if exactly 24 bits were taken. A frame with fewer or more bits changes no register.
- R3: Address 0001 selects channel A, 1000 selects channel B and 1001 selects both. Any other address, including 0000, changes no register.
- R4: Command 0001 loads the input register of each selected channel. The DAC register of a channel stays unchanged if `load_n` is high or if that channel's mask bit is 1.
- R5: When `load_n` is low and the channel's mask bit is 0, command 0001 also loads the same code into that channel's DAC register.
- R6: Command 0010 copies each selected input register into its DAC register.
- R7: Command 0011 loads the code into both the input register and the DAC register of each selected channel.
- R8: A falling edge on `load_n` copies the input register into the DAC register for every channel whose mask bit is 0. A masked channel keeps its DAC value.
- R9: Command 0101 loads the mask from data bits 1:0. Bit 0 belongs to channel A and bit 1 to channel B.
- R10: Command 0100 loads `pwr_mode` from data bits 3:0, with channel A in bits 1:0 and channel B in bits 3:2. Commands 0111, 1000 and 1001 load `ref_off`, `chain_en` and `rdbk_en` from data bit 0.
- R11: Command 0110 clears every register to zero.
- R12: Command 0000 and commands 1010 to 1111 change no register.
- R13: With `CODE_W`=12 the code is data bits 15:4, and data bits 3:0 are ignored. With the default of 16 the code is the whole data field.
- R14: `ser_dout` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its falling edge |
| ser_din | input | 1 | Serial data in |
| load_n | input | 1 | Active-low hardware load pin |
| dac_a_code | output | CODE_W | Channel A DAC register |
| dac_b_code | output | CODE_W | Channel B DAC register |
| pwr_mode | output | 4 | Power mode of both channels |
| load_mask | output | 2 | Load-pin mask, one bit per channel |
| ref_off | output | 1 | Reference control bit |
| chain_en | output | 1 | Daisy-chain enable bit |
| rdbk_en | output | 1 | Readback enable bit |
| ser_dout | output | 1 | Serial data out, held low |

## Verification
Frames go to channel A alone, to channel B alone and to both channels, so that a wrong address decode shows up on the channel that should have kept its value. The same input writes are repeated with the load pin high, with the load pin held low, and with one channel masked. This separates a deferred transfer from an immediate transfer and shows whether the mask is obeyed. Frames of 23 and 25 bits, reserved and no-op commands, and invalid addresses each follow a known state, and the outputs must show that state unchanged. A second instance with 12-bit codes receives the same frames, so it shows which data bits form its code.

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              load_n,
  output logic [CODE_W-1:0] dac_a_code,
  output logic [CODE_W-1:0] dac_b_code,
  output logic [3:0]        pwr_mode,
  output logic [1:0]        load_mask,
  output logic              ref_off,
  output logic              chain_en,
  output logic              rdbk_en,
  output logic              ser_dout
);
  localparam int FRAME_W = 24;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic fr_q, fr_p, ck_q, ck_p, di_q, ld_q, ld_p;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [CODE_W-1:0]  in_a, in_b;

  wire sck_fall = ck_p & ~ck_q;
  wire fr_start = fr_p & ~fr_q;
  wire fr_end   = ~fr_p & fr_q;
  wire ld_fall  = ld_p & ~ld_q;
  wire commit   = fr_end && (cnt == CNT_W'(FRAME_W));

  wire [3:0]        cmd  = shreg[23:20];
  wire [3:0]        addr = shreg[19:16];
  wire [15:0]       data = shreg[15:0];
  wire [CODE_W-1:0] code = data[15 -: CODE_W];
  wire sel_a   = (addr == 4'b0001) || (addr == 4'b1001);
  wire sel_b   = (addr == 4'b1000) || (addr == 4'b1001);
  wire addr_ok = sel_a || sel_b;

  assign ser_dout = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fr_q, fr_p, ck_q, ck_p, ld_q, ld_p} <= '1;
      di_q <= 1'b0;
    end else begin
      fr_q <= frame_n;  fr_p <= fr_q;
      ck_q <= ser_clk;  ck_p <= ck_q;
      ld_q <= load_n;   ld_p <= ld_q;
      di_q <= ser_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (fr_start) begin
      cnt <= '0;
    end else if (sck_fall && !fr_q && cnt <= CNT_W'(FRAME_W)) begin
      shreg <= {shreg[FRAME_W-2:0], di_q};
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a <= '0; in_b <= '0; dac_a_code <= '0; dac_b_code <= '0;
      pwr_mode <= '0; load_mask <= '0;
      ref_off <= 1'b0; chain_en <= 1'b0; rdbk_en <= 1'b0;
    end else begin
      if (ld_fall) begin
        if (!load_mask[0]) dac_a_code <= in_a;
        if (!load_mask[1]) dac_b_code <= in_b;
      end
      if (commit && addr_ok) begin
        case (cmd)
          4'b0001: begin
            if (sel_a) begin
              in_a <= code;
              if (!ld_q && !load_mask[0]) dac_a_code <= code;
            end
            if (sel_b) begin
              in_b <= code;
              if (!ld_q && !load_mask[1]) dac_b_code <= code;
            end
          end
          4'b0010: begin
            if (sel_a) dac_a_code <= in_a;
            if (sel_b) dac_b_code <= in_b;
          end
          4'b0011: begin
            if (sel_a) begin in_a <= code; dac_a_code <= code; end
            if (sel_b) begin in_b <= code; dac_b_code <= code; end
          end
          4'b0100: pwr_mode  <= data[3:0];
          4'b0101: load_mask <= data[1:0];
          4'b0110: begin
            in_a <= '0; in_b <= '0; dac_a_code <= '0; dac_b_code <= '0;
            pwr_mode <= '0; load_mask <= '0;
            ref_off <= 1'b0; chain_en <= 1'b0; rdbk_en <= 1'b0;
          end
          4'b0111: ref_off  <= data[0];
          4'b1000: chain_en <= data[0];
          4'b1001: rdbk_en  <= data[0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk #(
  parameter int CODE_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              ld_fall,
  input logic              addr_ok,
  input logic [3:0]        cmd,
  input logic [CNT_W-1:0]  cnt,
  input logic [CODE_W-1:0] in_a,
  input logic [CODE_W-1:0] in_b,
  input logic [CODE_W-1:0] dac_a_code,
  input logic [CODE_W-1:0] dac_b_code,
  input logic [3:0]        pwr_mode,
  input logic [1:0]        load_mask,
  input logic              ref_off,
  input logic              chain_en,
  input logic              rdbk_en
);
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(25));

  a_r2_no_frame_no_input: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(in_a) && $stable(in_b) && $stable(pwr_mode) && $stable(load_mask));

  a_r2_dac_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !ld_fall |=> $stable(dac_a_code) && $stable(dac_b_code));

  a_r3_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !addr_ok && !ld_fall |=> $stable(in_a) && $stable(dac_a_code)
      && $stable(in_b) && $stable(dac_b_code) && $stable(pwr_mode) && $stable(rdbk_en));

  a_r8_load_copies_a: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall && !commit && !load_mask[0] |=> dac_a_code == $past(in_a));

  a_r8_mask_holds_b: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall && !commit && load_mask[1] |=> $stable(dac_b_code));

  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    commit && addr_ok && cmd == 4'b0110 |=> dac_a_code == '0 && dac_b_code == '0
      && in_a == '0 && in_b == '0 && pwr_mode == '0 && load_mask == '0
      && !ref_off && !chain_en && !rdbk_en);

  a_r12_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (cmd >= 4'b1010 || cmd == 4'b0000) && !ld_fall |=> $stable(in_a)
      && $stable(dac_a_code) && $stable(dac_b_code) && $stable(load_mask) && $stable(chain_en));
endmodule

bind dac_serial_front dac_serial_front_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .ld_fall(ld_fall), .addr_ok(addr_ok),
  .cmd(cmd), .cnt(cnt), .in_a(in_a), .in_b(in_b),
  .dac_a_code(dac_a_code), .dac_b_code(dac_b_code), .pwr_mode(pwr_mode),
  .load_mask(load_mask), .ref_off(ref_off), .chain_en(chain_en), .rdbk_en(rdbk_en)
);

// File: tb/sim_dac_serial_front.sv
`timescale 1ns/1ps
module sim_dac_serial_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0, load_n = 1'b1;
  logic [15:0] da, db;
  logic [11:0] da12, db12;
  logic [3:0] pwr;
  logic [1:0] msk;
  logic rf, ch, rb, sdo;
  logic [3:0] pwr1;
  logic [1:0] msk1;
  logic rf1, ch1, rb1, sdo1;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_serial_front #(.CODE_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .load_n(load_n), .dac_a_code(da), .dac_b_code(db), .pwr_mode(pwr), .load_mask(msk),
    .ref_off(rf), .chain_en(ch), .rdbk_en(rb), .ser_dout(sdo));

  dac_serial_front #(.CODE_W(12)) u1 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .load_n(load_n), .dac_a_code(da12), .dac_b_code(db12), .pwr_mode(pwr1), .load_mask(msk1),
    .ref_off(rf1), .chain_en(ch1), .rdbk_en(rb1), .ser_dout(sdo1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d,
                      input int nb);
    logic [23:0] w;
    w = {c, a, d};
    @(negedge clk) frame_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      ser_clk = 1'b1;
      ser_din = (i < 24) ? w[23-i] : 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    frame_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk) load_n = 1'b0;
    repeat (4) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R14 reset dac a", 32'(da), 0);
    chk("R14 reset dac b", 32'(db), 0);
    chk("R14 reset ctrl", {pwr, msk, rf, ch, rb}, 0);
    chk("R14 dout low", 32'(sdo), 0);
  endtask

  task automatic t_input_then_update();
    send(4'b0001, 4'b0001, 16'h1234, 24);
    chk("R4 input write leaves dac a", 32'(da), 0);
    send(4'b0010, 4'b0001, 16'h0000, 24);
    chk("R6 update copies to dac a", 32'(da), 32'h1234);
    chk("R6 dac b untouched", 32'(db), 0);
  endtask

  task automatic t_address();
    send(4'b0011, 4'b1000, 16'hBEEF, 24);
    chk("R3 R7 addr B writes b", 32'(db), 32'hBEEF);
    chk("R3 addr B leaves a", 32'(da), 32'h1234);
    send(4'b0011, 4'b1001, 16'h5555, 24);
    chk("R3 R7 both a", 32'(da), 32'h5555);
    chk("R3 R7 both b", 32'(db), 32'h5555);
    send(4'b0011, 4'b0000, 16'hAAAA, 24);
    chk("R3 addr 0000 ignored", {da, db}, 32'h55555555);
    send(4'b0011, 4'b0101, 16'hAAAA, 24);
    chk("R3 addr 0101 ignored", {da, db}, 32'h55555555);
  endtask

  task automatic t_load_pin();
    send(4'b0001, 4'b1001, 16'h0F0F, 24);
    chk("R4 load high defers", {da, db}, 32'h55555555);
    pulse_load();
    chk("R8 load edge copies both", {da, db}, 32'h0F0F0F0F);
    send(4'b0101, 4'b0001, 16'h0002, 24);
    chk("R9 mask loaded", 32'(msk), 2);
    send(4'b0001, 4'b1001, 16'h7777, 24);
    pulse_load();
    chk("R8 unmasked a copied", 32'(da), 32'h7777);
    chk("R8 R9 masked b held", 32'(db), 32'h0F0F);
  endtask

  task automatic t_load_low();
    @(negedge clk) load_n = 1'b0;
    repeat (4) @(negedge clk);
    send(4'b0001, 4'b0001, 16'h3333, 24);
    chk("R5 load low writes dac a", 32'(da), 32'h3333);
    send(4'b0001, 4'b1000, 16'h4444, 24);
    chk("R4 masked b not written", 32'(db), 32'h0F0F);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    send(4'b0010, 4'b1000, 16'h0000, 24);
    chk("R6 b input held 4444", 32'(db), 32'h4444);
  endtask

  task automatic t_controls();
    send(4'b0100, 4'b0001, 16'h000E, 24);
    chk("R10 power mode", 32'(pwr), 32'hE);
    send(4'b0111, 4'b0001, 16'h0001, 24);
    send(4'b1000, 4'b0001, 16'h0001, 24);
    send(4'b1001, 4'b0001, 16'h0001, 24);
    chk("R10 ref chain rdbk", {rf, ch, rb}, 32'h7);
  endtask

  task automatic t_reserved();
    send(4'b1010, 4'b1001, 16'hFFFF, 24);
    send(4'b1111, 4'b1001, 16'hFFFF, 24);
    send(4'b0000, 4'b1001, 16'hFFFF, 24);
    chk("R12 reserved dacs held", {da, db}, 32'h33334444);
    chk("R12 reserved ctrl held", {pwr, msk, rf, ch, rb}, {23'd0, 4'hE, 2'd2, 3'd7});
  endtask

  task automatic t_bad_length();
    send(4'b0011, 4'b1001, 16'h9999, 23);
    chk("R2 23 bits discarded", {da, db}, 32'h33334444);
    send(4'b0011, 4'b1001, 16'h9999, 25);
    chk("R2 25 bits discarded", {da, db}, 32'h33334444);
  endtask

  task automatic t_soft_reset();
    send(4'b0110, 4'b0001, 16'h0000, 24);
    chk("R11 dacs cleared", {da, db}, 0);
    chk("R11 ctrl cleared", {pwr, msk, rf, ch, rb}, 0);
    send(4'b0010, 4'b1001, 16'h0000, 24);
    chk("R11 inputs cleared", {da, db}, 0);
  endtask

  task automatic t_code_width();
    send(4'b0011, 4'b0001, 16'hABCD, 24);
    chk("R1 R13 16-bit code", 32'(da), 32'hABCD);
    chk("R13 12-bit code", 32'(da12), 32'hABC);
    chk("R14 dout low after traffic", {31'd0, sdo}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_input_then_update();
    t_address();
    t_load_pin();
    t_load_low();
    t_controls();
    t_reserved();
    t_bad_length();
    t_soft_reset();
    t_code_width();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule